// File: doc/BRIEF.md
# Display Line Prefetch Engine with Underrun Skip

This block sits between a frame store in memory and a display pixel pipe. During the line before each visible display line it reads that line's 32-bit pixel words, one word per accepted memory transfer, into one half of a two-half line buffer. While the line is shown, the other half is streamed out, one pixel for each cycle in which the display enable input is high. Both sides run on one clock, and an external timing generator supplies the line and frame strobes and the enable.

When memory bandwidth runs short and a line's fetch is still unfinished at the next line strobe, the remaining reads are dropped. The half-filled buffer is shown as it stands, and the fetch of the following line begins at its first word. The display therefore never stalls, and fetch and display stay on the same line. A small saturating counter records every abandoned fetch.

Line timing is set by parameters: sync, back porch, active and front porch line counts, pixels per line, and the byte stride between lines in memory. The frame base address is captured on the frame strobe.

Top module: `line_prefetch`

## Requirements
- R1: Synchronous active-high reset clears the line counter, the skip counter and both buffer halves. After reset no read is requested, pix_de is 0 and pix_data is 0. A line shown before any fetch gives zero for every pixel.
- R2: pix_de equals de delayed by one clock. pix_data is zero in every cycle in which pix_de is 0.
- R3: The line counter is 0 on the line opened by frame_start and rises by one at each line_start. Reads are requested only during lines whose count lies between VSYNC_LINES+VBP_LINES-1 and VSYNC_LINES+VBP_LINES+VACT_LINES-2, inclusive. Each such line prefetches the display line that follows it.
- R4: Fetching starts in the cycle after the line strobe. Word w of display line k is read from base + k*LINE_STRIDE + 4*w, with w rising from 0. base is frame_base captured at frame_start. A word is transferred in a cycle where mem_rd_req and mem_rd_valid are both 1, and the address then moves on by 4.
- R5: After PIX_PER_LINE words are transferred, mem_rd_req stays low until the next line strobe.
- R6: During a line, the n-th enabled cycle after the line strobe (n from 0) shows word n of the buffer half filled during the previous line. Once the last word is reached, it is held while de stays high.
- R7: A line strobe that finds the current fetch incomplete abandons the remaining words and adds one to skip_cnt. The new line's fetch, if any, starts at its word 0.
- R8: After an abandoned fetch, the next line shows that half as it stands: the new words that arrived, and older contents elsewhere. Pixels are still produced on every enabled cycle.
- R9: A transfer of the last word in the same cycle as the line strobe completes the line, and skip_cnt is not changed.
- R10: Without frame_start, the line counter holds at VSYNC_LINES+VBP_LINES+VACT_LINES+VFP_LINES-1, so no fetch starts again until the next frame.
- R11: skip_cnt holds at all ones once it gets there. It changes only on an abandoned fetch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for memory and display sides |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Strobe opening line 0 of a frame (also acts as a line strobe) |
| line_start | input | 1 | Strobe opening each line |
| frame_base | input | 32 | Frame base byte address, captured at frame_start |
| de | input | 1 | Display enable from the timing generator |
| mem_rd_req | output | 1 | Read request |
| mem_rd_addr | output | 32 | Byte address of the requested word |
| mem_rd_valid | input | 1 | Memory returns the requested word this cycle |
| mem_rd_data | input | 32 | Returned pixel word |
| pix_de | output | 1 | Registered display enable |
| pix_data | output | 32 | Registered pixel, zero outside enable |
| skip_cnt | output | SKIP_W | Saturating count of abandoned line fetches |

## Verification
The bench starves fetches in several ways: no words at all, a few words and then silence, and a late burst whose last word lands exactly on the line strobe. A design that stalls the display or keeps going with old addresses would show shifted pixels. A design that counts the boundary-cycle transfer as a skip would give a wrong skip_cnt. Lines after the final blanking line without a new frame strobe are also run, and a counter that wraps instead of holding would issue reads there. The skip counter is driven past its maximum, and a wrapping counter would drop back to zero.

// File: rtl/lpf_pkg.sv
package lpf_pkg;
  typedef logic [31:0] word_t;

  // True when a line count falls inside the prefetch window
  function automatic logic in_fetch_window(int unsigned vl, int unsigned first, int unsigned last);
    return (vl >= first) && (vl <= last);
  endfunction

  // Byte address of one pixel word inside the frame store
  function automatic word_t line_word_addr(word_t base, int unsigned line_idx,
                                           int unsigned word_idx, int unsigned stride);
    return base + word_t'(line_idx * stride) + word_t'(word_idx * 4);
  endfunction
endpackage

// File: rtl/lpf_vtrack.sv
module lpf_vtrack #(
  parameter int VTOTAL = 525,
  parameter int VL_W   = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            line_start,
  input  logic            frame_start,
  output logic            line_evt,
  output logic [VL_W-1:0] vline_q,
  output logic [VL_W-1:0] vline_nx
);
  assign line_evt = line_start | frame_start;

  always_comb begin
    if (frame_start)                         vline_nx = '0;
    else if (vline_q == VL_W'(VTOTAL - 1))   vline_nx = vline_q;
    else                                     vline_nx = vline_q + VL_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst)           vline_q <= '0;
    else if (line_evt) vline_q <= vline_nx;
  end
endmodule

// File: rtl/lpf_fetch.sv
module lpf_fetch
  import lpf_pkg::*;
#(
  parameter int PIX         = 640,
  parameter int PX_W        = 10,
  parameter int VL_W        = 10,
  parameter int FETCH_FIRST = 32,
  parameter int FETCH_LAST  = 511,
  parameter int LINE_STRIDE = 4096,
  parameter int SKIP_W      = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_evt,
  input  logic              frame_start,
  input  word_t             frame_base,
  input  logic [VL_W-1:0]   vline_nx,
  input  logic              mem_rd_valid,
  output logic              mem_rd_req,
  output word_t             mem_rd_addr,
  output logic              wr_en,
  output logic [PX_W-1:0]   wr_idx,
  output logic              fetch_last,
  output logic              skip_evt,
  output logic [SKIP_W-1:0] skip_cnt
);
  logic            busy_q;
  logic [PX_W-1:0] word_q;
  logic [VL_W-1:0] idx_q;
  word_t           base_q;
  logic            fire;

  assign fire       = busy_q & mem_rd_valid;
  assign fetch_last = (word_q == PX_W'(PIX - 1));
  assign skip_evt   = line_evt & busy_q & ~(fire & fetch_last);

  assign mem_rd_req  = busy_q;
  assign mem_rd_addr = line_word_addr(base_q, 32'(idx_q), 32'(word_q), LINE_STRIDE);
  assign wr_en       = fire;
  assign wr_idx      = word_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      word_q   <= '0;
      idx_q    <= '0;
      base_q   <= '0;
      skip_cnt <= '0;
    end else begin
      if (frame_start) base_q <= frame_base;
      if (line_evt) begin
        busy_q <= in_fetch_window(32'(vline_nx), FETCH_FIRST, FETCH_LAST);
        word_q <= '0;
        idx_q  <= vline_nx - VL_W'(FETCH_FIRST);
      end else if (fire) begin
        if (fetch_last) busy_q <= 1'b0;
        else            word_q <= word_q + PX_W'(1);
      end
      if (skip_evt && (skip_cnt != '1)) skip_cnt <= skip_cnt + SKIP_W'(1);
    end
  end
endmodule

// File: rtl/lpf_linebuf.sv
module lpf_linebuf
  import lpf_pkg::*;
#(
  parameter int PIX  = 640,
  parameter int PX_W = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            line_evt,
  input  logic            wr_en,
  input  logic [PX_W-1:0] wr_idx,
  input  word_t           wr_data,
  input  logic            de,
  output logic            pix_de,
  output word_t           pix_data
);
  word_t           mem_q [2][PIX];
  logic            fill_q;
  logic [PX_W-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int h = 0; h < 2; h++)
        for (int p = 0; p < PIX; p++)
          mem_q[h][p] <= '0;
      fill_q   <= 1'b0;
      rd_q     <= '0;
      pix_de   <= 1'b0;
      pix_data <= '0;
    end else begin
      if (wr_en) mem_q[fill_q][wr_idx] <= wr_data;
      if (line_evt) begin
        fill_q <= ~fill_q;
        rd_q   <= '0;
      end else if (de && (rd_q != PX_W'(PIX - 1))) begin
        rd_q <= rd_q + PX_W'(1);
      end
      pix_de   <= de;
      pix_data <= de ? mem_q[~fill_q][rd_q] : '0;
    end
  end
endmodule

// File: rtl/line_prefetch.sv
module line_prefetch
  import lpf_pkg::*;
#(
  parameter int PIX_PER_LINE = 640,
  parameter int VSYNC_LINES  = 2,
  parameter int VBP_LINES    = 31,
  parameter int VACT_LINES   = 480,
  parameter int VFP_LINES    = 12,
  parameter int LINE_STRIDE  = 4096,
  parameter int SKIP_W       = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start,
  input  logic              line_start,
  input  logic [31:0]       frame_base,
  input  logic              de,
  output logic              mem_rd_req,
  output logic [31:0]       mem_rd_addr,
  input  logic              mem_rd_valid,
  input  logic [31:0]       mem_rd_data,
  output logic              pix_de,
  output logic [31:0]       pix_data,
  output logic [SKIP_W-1:0] skip_cnt
);
  localparam int VTOTAL      = VSYNC_LINES + VBP_LINES + VACT_LINES + VFP_LINES;
  localparam int VL_W        = $clog2(VTOTAL);
  localparam int PX_W        = $clog2(PIX_PER_LINE);
  localparam int FETCH_FIRST = VSYNC_LINES + VBP_LINES - 1;
  localparam int FETCH_LAST  = FETCH_FIRST + VACT_LINES - 1;

  // Internal events brought out by name for the checker
  logic            line_evt;
  logic            skip_evt;
  logic            fetch_last;
  logic [VL_W-1:0] vline_q;
  logic [VL_W-1:0] vline_nx;
  logic            wr_en;
  logic [PX_W-1:0] wr_idx;

  lpf_vtrack #(.VTOTAL(VTOTAL), .VL_W(VL_W)) i_vtrack (
    .clk(clk), .rst(rst), .line_start(line_start), .frame_start(frame_start),
    .line_evt(line_evt), .vline_q(vline_q), .vline_nx(vline_nx)
  );

  lpf_fetch #(
    .PIX(PIX_PER_LINE), .PX_W(PX_W), .VL_W(VL_W), .FETCH_FIRST(FETCH_FIRST),
    .FETCH_LAST(FETCH_LAST), .LINE_STRIDE(LINE_STRIDE), .SKIP_W(SKIP_W)
  ) i_fetch (
    .clk(clk), .rst(rst), .line_evt(line_evt), .frame_start(frame_start),
    .frame_base(frame_base), .vline_nx(vline_nx), .mem_rd_valid(mem_rd_valid),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .wr_en(wr_en),
    .wr_idx(wr_idx), .fetch_last(fetch_last), .skip_evt(skip_evt),
    .skip_cnt(skip_cnt)
  );

  lpf_linebuf #(.PIX(PIX_PER_LINE), .PX_W(PX_W)) i_linebuf (
    .clk(clk), .rst(rst), .line_evt(line_evt), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(mem_rd_data), .de(de), .pix_de(pix_de), .pix_data(pix_data)
  );
endmodule

// File: rtl/lpf_checker.sv
module lpf_checker
  import lpf_pkg::*;
#(
  parameter int VL_W        = 10,
  parameter int SKIP_W      = 16,
  parameter int FETCH_FIRST = 32,
  parameter int FETCH_LAST  = 511
) (
  input logic              clk,
  input logic              rst,
  input logic              de,
  input logic              pix_de,
  input logic [31:0]       pix_data,
  input logic              mem_rd_req,
  input logic              mem_rd_valid,
  input logic [31:0]       mem_rd_addr,
  input logic [SKIP_W-1:0] skip_cnt,
  input logic              skip_evt,
  input logic              line_evt,
  input logic              fetch_last,
  input logic [VL_W-1:0]   vline_q
);
  assert_enable_delay_R2: assert property (@(posedge clk) disable iff (rst)
    de |=> pix_de) else $error("pix_de did not follow de");

  assert_enable_drop_R2: assert property (@(posedge clk) disable iff (rst)
    !de |=> !pix_de) else $error("pix_de high without de");

  assert_pix_zero_R2: assert property (@(posedge clk) disable iff (rst)
    !pix_de |-> (pix_data == '0)) else $error("pixel not zero outside enable");

  assert_req_in_window_R3: assert property (@(posedge clk) disable iff (rst)
    mem_rd_req |-> in_fetch_window(32'(vline_q), FETCH_FIRST, FETCH_LAST))
    else $error("read outside prefetch window");

  assert_addr_step_R4: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_req && mem_rd_valid && !fetch_last && !line_evt)
      |=> (mem_rd_req && (mem_rd_addr == $past(mem_rd_addr) + 32'd4)))
    else $error("address did not advance by one word");

  assert_done_idle_R5: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_req && mem_rd_valid && fetch_last && !line_evt) |=> !mem_rd_req)
    else $error("request after last word");

  assert_skip_step_R7: assert property (@(posedge clk) disable iff (rst)
    (skip_evt && (skip_cnt != '1)) |=> (skip_cnt == $past(skip_cnt) + SKIP_W'(1)))
    else $error("skip counter did not step");

  assert_skip_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (!skip_evt || (skip_cnt == '1)) |=> $stable(skip_cnt))
    else $error("skip counter moved without a skip");
endmodule

bind line_prefetch lpf_checker #(
  .VL_W(VL_W), .SKIP_W(SKIP_W), .FETCH_FIRST(FETCH_FIRST), .FETCH_LAST(FETCH_LAST)
) i_lpf_checker (
  .clk(clk), .rst(rst), .de(de), .pix_de(pix_de), .pix_data(pix_data),
  .mem_rd_req(mem_rd_req), .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
  .skip_cnt(skip_cnt), .skip_evt(skip_evt), .line_evt(line_evt),
  .fetch_last(fetch_last), .vline_q(vline_q)
);

// File: tb/test_line_prefetch.sv
module test_line_prefetch;
  localparam int CLK_PERIOD = 10;
  localparam int PIX    = 8;
  localparam int VS     = 1;
  localparam int VBP    = 2;
  localparam int VACT   = 4;
  localparam int VFP    = 1;
  localparam int VT     = VS + VBP + VACT + VFP;
  localparam int FIRST  = VS + VBP - 1;
  localparam int LAST   = FIRST + VACT - 1;
  localparam int STRIDE = 64;
  localparam int SKW    = 2;
  localparam int MAXS   = (1 << SKW) - 1;
  localparam int LP     = 16;
  localparam int DE_ON  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fs_i = 1'b0, ls_i = 1'b0, de_i = 1'b0, valid_i = 1'b0;
  logic [31:0] base_i = '0;
  logic mem_rd_req, pix_de;
  logic [31:0] mem_rd_addr, mem_rd_data, pix_data;
  logic [SKW-1:0] skip_cnt;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] mdata(logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction

  assign mem_rd_data = mdata(mem_rd_addr);

  line_prefetch #(
    .PIX_PER_LINE(PIX), .VSYNC_LINES(VS), .VBP_LINES(VBP), .VACT_LINES(VACT),
    .VFP_LINES(VFP), .LINE_STRIDE(STRIDE), .SKIP_W(SKW)
  ) i_line_prefetch (
    .clk(clk), .rst(rst), .frame_start(fs_i), .line_start(ls_i), .frame_base(base_i),
    .de(de_i), .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(valid_i), .mem_rd_data(mem_rd_data), .pix_de(pix_de),
    .pix_data(pix_data), .skip_cnt(skip_cnt)
  );

  // Behavioural reference model
  logic [31:0] m_buf [2][PIX];
  int   m_vline, m_word, m_idx, m_skip, m_rd, m_fill;
  bit   m_fetch, m_pde, m_seen_frame;
  logic [31:0] m_pix, m_base;
  string pix_tag = "R1";
  string req_tag = "R3";
  int   prev_mode = 0;
  logic [31:0] lf = 32'h1234_5678;

  function automatic logic [31:0] exp_addr();
    return m_base + 32'(m_idx * STRIDE) + 32'(m_word * 4);
  endfunction

  task automatic model_step();
    bit fire, newl;
    if (rst) begin
      foreach (m_buf[h, p]) m_buf[h][p] = '0;
      m_vline = 0; m_word = 0; m_idx = 0; m_skip = 0; m_rd = 0; m_fill = 0;
      m_fetch = 0; m_pde = 0; m_pix = '0; m_base = '0;
      return;
    end
    fire = m_fetch && valid_i;
    newl = ls_i || fs_i;
    m_pix = de_i ? m_buf[1 - m_fill][m_rd] : '0;
    m_pde = de_i;
    if (newl) m_rd = 0;
    else if (de_i && m_rd < PIX - 1) m_rd++;
    if (fire) m_buf[m_fill][m_word] = mdata(exp_addr());
    if (newl) begin
      bit skipped;
      skipped = m_fetch && !(fire && m_word == PIX - 1);
      if (skipped && m_skip < MAXS) m_skip++;
      if (fs_i) begin m_vline = 0; m_base = base_i; m_seen_frame = 1; end
      else if (m_vline < VT - 1) m_vline++;
      m_fill = 1 - m_fill;
      m_fetch = (m_vline >= FIRST) && (m_vline <= LAST);
      m_word = 0;
      m_idx = m_vline - FIRST;
      if (m_seen_frame) pix_tag = skipped ? "R8" : "R6";
    end else if (fire) begin
      if (m_word == PIX - 1) m_fetch = 0;
      else m_word++;
    end
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    string rt;
    bit win;
    win = (m_vline >= FIRST) && (m_vline <= LAST);
    rt = (!m_fetch && win) ? "R5" : req_tag;
    chk(rst ? "R1" : rt, 32'(mem_rd_req), 32'(m_fetch));
    if (m_fetch) chk("R4", mem_rd_addr, exp_addr());
    chk(rst ? "R1" : "R2", 32'(pix_de), 32'(m_pde));
    chk(rst ? "R1" : pix_tag, pix_data, m_pix);
    chk(rst ? "R1" : "R7", 32'(skip_cnt), 32'(m_skip));
  endtask

  task automatic cycle();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  // mode 0: always valid, 1: pseudo-random, 2: never, 3: first three cycles,
  // 4: late burst whose last word lands on the next line strobe
  task automatic run_line(bit fs, int mode);
    for (int cyc = 0; cyc < LP; cyc++) begin
      ls_i = (cyc == 0);
      fs_i = fs && (cyc == 0);
      de_i = (cyc >= DE_ON) && (cyc < DE_ON + PIX);
      lf = lf * 32'd1103515245 + 32'd12345;
      if (cyc == 0) valid_i = (prev_mode == 4);
      else case (mode)
        0: valid_i = 1'b1;
        1: valid_i = lf[16];
        2: valid_i = 1'b0;
        3: valid_i = (cyc <= 3);
        default: valid_i = (cyc >= LP - (PIX - 1));
      endcase
      cycle();
    end
    prev_mode = mode;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    rst = 1'b1;
    repeat (3) cycle();
    // R1: reset state at the ports
    chk("R1", 32'(mem_rd_req), 32'd0);
    chk("R1", pix_data, 32'd0);
    chk("R1", 32'(skip_cnt), 32'd0);
    rst = 1'b0;
    // R1: both halves read out as zero before any fetch
    run_line(0, 0);
    run_line(0, 0);

    // Frame A: memory always ready (R4, R5, R6)
    base_i = 32'h0000_1000;
    run_line(1, 0);
    for (int l = 1; l < VT; l++) run_line(0, 0);
    // R10: no frame strobe, the line counter must hold and stay out of the window
    req_tag = "R10";
    for (int l = 0; l < 3; l++) run_line(0, 0);
    req_tag = "R3";

    // Frame C: partial fetch, empty fetch, late burst on the boundary
    base_i = 32'h0000_2000;
    run_line(1, 0);
    run_line(0, 0);
    run_line(0, 3);   // line 2 fetch: only three words, skip (R7, R8)
    run_line(0, 0);
    run_line(0, 2);   // line 4 fetch: no words, skip
    run_line(0, 4);   // line 5 fetch: last word on the strobe
    run_line(0, 0);
    // R9: the boundary transfer completed the line, count stays at two
    chk("R9", 32'(skip_cnt), 32'd2);
    run_line(0, 0);

    // Frame B: pseudo-random memory readiness
    base_i = 32'h0000_8000;
    run_line(1, 1);
    for (int l = 1; l < VT; l++) run_line(0, 1);

    // Frame D: starve every fetch, counter must saturate
    base_i = 32'h0000_3000;
    run_line(1, 2);
    for (int l = 1; l < VT; l++) run_line(0, 2);
    run_line(1, 0);
    chk("R11", 32'(skip_cnt), 32'(MAXS));

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule